// File: doc/BRIEF.md
# Multi-Mode Test Register (Built-In Logic Block Observer)

This block is a small register that serves the test logic of a larger chip in four roles. A 2-bit mode code selects the role. As an ordinary parallel register, it captures a data word on each clock. As a scan chain, it shifts a serial stream from one end to the other, so its contents can be loaded or unloaded. As an autonomous pseudo-random pattern generator, it steps a linear feedback shift register. As a multiple-input signature register, it folds a parallel response word into the same feedback shift. All four roles share one register and one feedback XOR network.

The feedback uses the primitive polynomial 1 + X + X^3. In generator mode the register therefore visits every nonzero 3-bit state once before it repeats. The all-zero state would freeze the generator, so the register never stays in it. If generator mode is entered with a zero state, the next clock loads the nonzero seed. Reset loads the same seed. The serial output is always the last stage, so a signature built up in compactor mode can be shifted out through scan mode. A test controller outside this block sequences the modes.

Top module: `bilbo_reg`

## Requirements
- R1: A synchronous active-high reset loads the state to the seed (q = 3'b100: q[2]=1, q[1]=0, q[0]=0).
- R2: Mode code {modeB1,modeB2} = 2'b10 (parallel mode): on each rising edge q takes the value of parIn.
- R3: Mode code 2'b00 (scan mode): on each rising edge q[2] takes scanIn, q[1] takes the old q[2] and q[0] takes the old q[1]. In every mode, scanOut equals the current q[0].
- R4: Mode code 2'b01 (generator mode), from a nonzero state: the next state is {q[0]^q[1], q[2], q[1]} (as {q[2],q[1],q[0]}), and parIn and scanIn have no effect.
- R5: Generator mode started from the seed visits 7 distinct nonzero states and returns to the seed on the 7th clock.
- R6: Generator mode entered with q = 3'b000 loads the seed 3'b100 on the next rising edge.
- R7: Mode code 2'b11 (signature mode): the next state is the generator step of R4 XORed bit by bit with parIn. An all-zero result is kept and is not replaced by the seed.
- R8: A change of the mode code governs the very next rising edge, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| modeB1 | input | 1 | Upper mode bit |
| modeB2 | input | 1 | Lower mode bit |
| parIn | input | 3 | Parallel data / response word |
| scanIn | input | 1 | Serial scan input, enters stage 2 |
| q | output | 3 | Register contents |
| scanOut | output | 1 | Serial scan output, stage 0 |

## Verification
Every state update is due exactly one rising edge after the mode, parIn and scanIn values that cause it. scanOut follows q with no further delay. The bench drives all inputs on the falling edge. It computes the expected next state with its own model function, waits through one rising edge, and compares q and scanOut on the following falling edge. The generator-period and zero-entry checks count edges in the same way: the first state is checked one edge after entry, and the seed is expected back after seven edges.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_GEN  = 2'b01,
    MODE_PAR  = 2'b10,
    MODE_SIG  = 2'b11
  } bilboMode_e;

  // Strobes from control to datapath; at most one of the selecting
  // strobes (loadPar, shiftScan, stepLfsr, forceSeed) is high.
  typedef struct packed {
    logic loadPar;
    logic shiftScan;
    logic stepLfsr;
    logic mixPar;
    logic forceSeed;
  } bilboStrobe_t;

endpackage

// File: rtl/bilbo_ctrl.sv
module bilbo_ctrl
  import bilbo_pkg::*;
(
  input  logic         modeB1,
  input  logic         modeB2,
  input  logic         stateZero,
  output bilboStrobe_t strobe
);

  bilboMode_e modeSel;

  assign modeSel = bilboMode_e'({modeB1, modeB2});

  always_comb begin
    strobe = '0;
    unique case (modeSel)
      MODE_SCAN: strobe.shiftScan = 1'b1;
      MODE_GEN: begin
        // a zero state would lock the generator: reseed instead
        if (stateZero) strobe.forceSeed = 1'b1;
        else           strobe.stepLfsr  = 1'b1;
      end
      MODE_PAR:  strobe.loadPar = 1'b1;
      MODE_SIG: begin
        strobe.stepLfsr = 1'b1;
        strobe.mixPar   = 1'b1;
      end
      default:   strobe = '0;
    endcase
  end

endmodule

// File: rtl/bilbo_dpath.sv
module bilbo_dpath
  import bilbo_pkg::*;
#(
  parameter int           W    = 3,
  parameter logic [W-1:0] TAPS = 3'b011,
  parameter logic [W-1:0] SEED = 3'b100
) (
  input  logic         clk,
  input  logic         rst,
  input  bilboStrobe_t strobe,
  input  logic [W-1:0] parIn,
  input  logic         scanIn,
  output logic [W-1:0] q,
  output logic         scanOut,
  output logic         stateZero
);

  localparam int TOP = W - 1;

  logic [W-1:0] stateReg;
  logic [W-1:0] stateNext;
  logic         feedback;

  // shared feedback network: XOR of tapped stages
  assign feedback = ^(stateReg & TAPS);

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic fromUp;
    logic stepBit;

    if (i == TOP) begin : g_top
      assign fromUp  = scanIn;
      assign stepBit = feedback;
    end else begin : g_mid
      assign fromUp  = stateReg[i+1];
      assign stepBit = stateReg[i+1];
    end

    always_comb begin
      if (strobe.forceSeed)      stateNext[i] = SEED[i];
      else if (strobe.shiftScan) stateNext[i] = fromUp;
      else if (strobe.stepLfsr)  stateNext[i] = stepBit ^ (strobe.mixPar & parIn[i]);
      else if (strobe.loadPar)   stateNext[i] = parIn[i];
      else                       stateNext[i] = stateReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateReg <= SEED;
    else     stateReg <= stateNext;
  end

  assign q         = stateReg;
  assign scanOut   = stateReg[0];
  assign stateZero = (stateReg == '0);

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int           W    = 3,
  parameter logic [W-1:0] TAPS = 3'b011,
  parameter logic [W-1:0] SEED = 3'b100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         modeB1,
  input  logic         modeB2,
  input  logic [W-1:0] parIn,
  input  logic         scanIn,
  output logic [W-1:0] q,
  output logic         scanOut
);

  bilboStrobe_t strobe;
  logic         stateZero;

  bilbo_ctrl u_ctrl (
    .modeB1    (modeB1),
    .modeB2    (modeB2),
    .stateZero (stateZero),
    .strobe    (strobe)
  );

  bilbo_dpath #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .parIn     (parIn),
    .scanIn    (scanIn),
    .q         (q),
    .scanOut   (scanOut),
    .stateZero (stateZero)
  );

endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
  parameter int           W    = 3,
  parameter logic [W-1:0] TAPS = 3'b011,
  parameter logic [W-1:0] SEED = 3'b100
) (
  input logic         clk,
  input logic         rst,
  input logic         modeB1,
  input logic         modeB2,
  input logic [W-1:0] parIn,
  input logic         scanIn,
  input logic [W-1:0] q,
  input logic         scanOut
);

  logic [1:0] modeCode;
  assign modeCode = {modeB1, modeB2};

  function automatic logic [W-1:0] stepOf(input logic [W-1:0] s);
    return {^(s & TAPS), s[W-1:1]};
  endfunction

  // R1
  reset_seed_chk: assert property (@(posedge clk) rst |=> q == SEED);

  // R2
  par_load_chk: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b10 |=> q == $past(parIn));

  // R3
  scan_shift_chk: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b00 |=> q == {$past(scanIn), $past(q[W-1:1])});

  // R3
  scan_out_chk: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b00 |=> scanOut == $past(q[1]));

  // R4
  gen_step_chk: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b01 && q != '0) |=> q == stepOf($past(q)));

  // R5
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b01 |=> q != '0);

  // R6
  gen_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b01 && q == '0) |=> q == SEED);

  // R7
  sig_mix_chk: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b11 |=> q == (stepOf($past(q)) ^ $past(parIn)));

endmodule

bind bilbo_reg bilbo_reg_chk #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .modeB1  (modeB1),
  .modeB2  (modeB2),
  .parIn   (parIn),
  .scanIn  (scanIn),
  .q       (q),
  .scanOut (scanOut)
);

// File: tb/test_bilbo_reg.sv
module test_bilbo_reg;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeB1 = 1'b1;
  logic       modeB2 = 1'b0;
  logic [2:0] parIn = 3'b000;
  logic       scanIn = 1'b0;
  logic [2:0] q;
  logic       scanOut;

  int errors = 0;
  int checks = 0;
  logic [2:0] model;

  always #5 clk = ~clk;

  bilbo_reg i_bilbo_reg (
    .clk(clk), .rst(rst), .modeB1(modeB1), .modeB2(modeB2),
    .parIn(parIn), .scanIn(scanIn), .q(q), .scanOut(scanOut)
  );

  function automatic logic [2:0] genStep(input logic [2:0] s);
    return {s[0] ^ s[1], s[2], s[1]};
  endfunction

  function automatic logic [2:0] refNext(input logic [1:0] m, input logic [2:0] s,
                                         input logic [2:0] z, input logic si);
    case (m)
      2'b00:   return {si, s[2], s[1]};
      2'b01:   return (s == 3'b000) ? 3'b100 : genStep(s);
      2'b10:   return z;
      default: return genStep(s) ^ z;
    endcase
  endfunction

  function automatic string tagOf(input logic [1:0] m, input logic [2:0] s);
    case (m)
      2'b00:   return "R3";
      2'b01:   return (s == 3'b000) ? "R6" : "R4";
      2'b10:   return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, compare at the next negedge
  task automatic stepCycle(input logic [1:0] m, input logic [2:0] z, input logic si,
                           input string tagIn);
    logic [2:0] exp;
    string tag;
    exp = refNext(m, model, z, si);
    tag = (tagIn == "") ? tagOf(m, model) : tagIn;
    {modeB1, modeB2} = m;
    parIn = z;
    scanIn = si;
    @(posedge clk);
    @(negedge clk);
    check(tag, {q, scanOut}, {exp, exp[0]});
    model = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = 3'b100;
    // R1 reset seed and scanOut tie
    check("R1", {q, scanOut}, 4'b1000);

    // R5: full generator period from the seed
    begin
      logic [7:0] seen = '0;
      for (int k = 1; k <= 7; k++) begin
        stepCycle(2'b01, $urandom, $urandom, "R5");
        if (k < 7) begin
          check("R5", {3'b000, seen[q]}, 4'b0000);
          check("R5", {3'b000, q == 3'b000}, 4'b0000);
        end
        seen[q] = 1'b1;
      end
      check("R5", {q, 1'b0}, {3'b100, 1'b0});
      check("R5", {seen[3:0], 1'b0} & 5'b11111, {4'b1110, 1'b0});
    end

    // R6: zero loaded in parallel mode, then generator mode
    stepCycle(2'b10, 3'b000, 1'b0, "R2");
    stepCycle(2'b01, 3'b111, 1'b1, "R6");
    // R7: signature producing zero is kept
    stepCycle(2'b10, 3'b101, 1'b0, "R2");
    stepCycle(2'b11, genStep(3'b101), 1'b0, "R7");
    check("R7", {q, 1'b0}, 4'b0000);
    // R8: modes switch every edge
    stepCycle(2'b10, 3'b011, 1'b1, "R8");
    stepCycle(2'b01, 3'b100, 1'b1, "R8");
    stepCycle(2'b00, 3'b111, 1'b0, "R8");
    stepCycle(2'b11, 3'b010, 1'b1, "R8");
    // R3: unload signature serially
    for (int k = 0; k < 3; k++) stepCycle(2'b00, 3'b000, 1'b1, "R3");
    // R4: parIn ignored in generator mode
    stepCycle(2'b01, 3'b111, 1'b1, "R4");
    stepCycle(2'b01, 3'b000, 1'b0, "R4");

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      stepCycle(m, 3'($urandom), 1'($urandom), "");
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", {q, scanOut}, 4'b1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule